// File: doc/BRIEF.md
# Dual-Link Mode Agreement Guard

This block decides whether the machine mode can be trusted. It receives the same mode over two separate timing paths. The event path raises one strobe line per mode. The data path delivers frames, and each frame carries a mode number and a time-of-day stamp. The block raises `mode_ok` only when three conditions hold together:

- both paths name the same mode;
- the event path has strobed recently enough to be considered alive;
- the data frame is not a repeat of the frame before it, judged by its time-of-day stamp.

The block also publishes the last mode on which both paths agreed.

Link receivers sit upstream and deliver already-decoded strobes and frames. A frame is consumed in the cycle its `dl_valid` is high. There is no back-pressure and no ready signal, because the frame stream is timed by the machine and cannot be stalled. Every verdict is registered, so it appears on the edge after the inputs that caused it. The heartbeat window is `LIMIT = CLK_KHZ * TIMEOUT_US / 1000` clock cycles. The defaults give about 9 ms at 100 MHz, which is more than one 120 Hz update period.

Top module: `mode_agree_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released, `mode_ok` is 0 and `mode_out` is 0 until a frame passes.
- R2: A cycle in which exactly bit i of `ev_strobe` is high records event mode i. A later frame with `dl_mode` equal to i, taken while the event path is alive and the stamp is fresh, sets `mode_ok` to 1 and `mode_out` to i on the next edge.
- R3: A single strobe taken at an edge keeps the event path alive for the next LIMIT edges. A frame at the LIMIT-th edge can still pass. At the edge after that, `mode_ok` drops to 0, with or without a frame.
- R4: A frame whose `dl_tod` equals the stamp of the previous frame fails and drives `mode_ok` to 0. The first frame after reset always fails, because it has no reference. Every frame, passing or failing, becomes the new reference.
- R5: A cycle with two or more `ev_strobe` bits high drives `mode_ok` to 0 on the next edge. It also discards the recorded event mode, so frames fail until a single strobe arrives. It does not extend the heartbeat window.
- R6: A frame whose `dl_mode` differs from the recorded event mode drives `mode_ok` to 0 on the next edge.
- R7: `mode_out` changes only on the edge after a passing frame. Failing frames and cycles without a frame leave it unchanged.
- R8: A frame is judged against the event state held before its own cycle. A strobe arriving in the same cycle as a frame affects only later frames.
- R9: Until the first single strobe after reset, every frame fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_strobe | input | NUM_MODES | Event-path strobes; bit i announces mode i |
| dl_valid | input | 1 | A data-path frame is present this cycle |
| dl_mode | input | MODE_W | Mode number carried by the frame |
| dl_tod | input | TOD_W | Time-of-day stamp carried by the frame |
| mode_ok | output | 1 | Both paths agree, the event path is alive and the frame is fresh |
| mode_out | output | MODE_W | Last mode on which both paths agreed |

## Verification
The hardest situations to reach from the ports are the exact edge of the heartbeat window and a strobe that lands in the same cycle as a frame. Random traffic almost never hits either of them on the exact cycle. Directed steps place a strobe, idle for exactly LIMIT-1 cycles and then present a frame, so the pass on the last live edge and the drop one edge later are both observed. A separate step presents a strobe together with a frame of the new mode. Random traffic with seeded quiet gaps, repeated stamps, wrong modes and occasional multi-strobe cycles then mixes these effects, and a cycle model in the bench tracks the outcome.

// File: rtl/mode_guard_pkg.sv
package mode_guard_pkg;

  // Outcome of one cycle of evaluation in the verdict register.
  typedef enum logic [1:0] {
    VERDICT_HOLD = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;

endpackage

// File: rtl/mg_strobe_encoder.sv
module mg_strobe_encoder #(
  parameter int NUM_MODES = 8,
  parameter int MODE_W    = 3
) (
  input  logic [NUM_MODES-1:0] strobe,
  output logic [MODE_W-1:0]    idx,
  output logic                 single,
  output logic                 multi
);

  logic [MODE_W-1:0][NUM_MODES-1:0] bitsel;

  // Each index bit is the OR of all strobe lines whose position has that bit set.
  for (genvar b = 0; b < MODE_W; b++) begin : g_bit
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_line
      localparam int unsigned IV = i;
      assign bitsel[b][i] = strobe[i] && (((IV >> b) & 1) != 0);
    end
    assign idx[b] = |bitsel[b];
  end

  int unsigned hot;
  always_comb begin
    hot    = $countones(strobe);
    single = (hot == 1);
    multi  = (hot > 1);
  end

endmodule

// File: rtl/mg_heartbeat.sv
module mg_heartbeat #(
  parameter int LIMIT = 900000,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic alive
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (reload)        cnt_q <= CW'(LIMIT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign alive = (cnt_q != '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT)); // R3

  AST_RELOAD_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> alive); // R3

endmodule

// File: rtl/mg_tod_track.sv
module mg_tod_track #(
  parameter int TOD_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic [TOD_W-1:0] tod,
  output logic             fresh
);

  logic [TOD_W-1:0] ref_q;
  logic             have_ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q      <= '0;
      have_ref_q <= 1'b0;
    end else if (frame_valid) begin
      ref_q      <= tod;
      have_ref_q <= 1'b1;
    end
  end

  assign fresh = have_ref_q && (tod != ref_q);

  AST_STALE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && $past(frame_valid) && (tod == $past(tod)) |-> !fresh); // R4

endmodule

// File: rtl/mode_agree_guard.sv
module mode_agree_guard
  import mode_guard_pkg::*;
#(
  parameter int NUM_MODES  = 8,
  parameter int TOD_W      = 24,
  parameter int CLK_KHZ    = 100000,
  parameter int TIMEOUT_US = 9000,
  parameter int MODE_W     = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MODES-1:0] ev_strobe,
  input  logic                 dl_valid,
  input  logic [MODE_W-1:0]    dl_mode,
  input  logic [TOD_W-1:0]     dl_tod,
  output logic                 mode_ok,
  output logic [MODE_W-1:0]    mode_out
);

  localparam int LIMIT = CLK_KHZ * TIMEOUT_US / 1000;

  logic [MODE_W-1:0] enc_idx;
  logic              enc_single;
  logic              enc_multi;
  logic              hb_alive;
  logic              tod_fresh;

  mg_strobe_encoder #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_enc (
    .strobe (ev_strobe),
    .idx    (enc_idx),
    .single (enc_single),
    .multi  (enc_multi)
  );

  mg_heartbeat #(.LIMIT(LIMIT)) u_hb (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (enc_single),
    .alive  (hb_alive)
  );

  mg_tod_track #(.TOD_W(TOD_W)) u_tod (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (dl_valid),
    .tod         (dl_tod),
    .fresh       (tod_fresh)
  );

  // Event-side mode as last announced by a single strobe.
  logic [MODE_W-1:0] ev_mode_q;
  logic              ev_live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_mode_q <= '0;
      ev_live_q <= 1'b0;
    end else if (enc_single) begin
      ev_mode_q <= enc_idx;
      ev_live_q <= 1'b1;
    end else if (enc_multi) begin
      ev_live_q <= 1'b0;
    end
  end

  verdict_e verdict;
  logic     agree;

  always_comb begin
    agree = ev_live_q && (dl_mode == ev_mode_q);
    if (!hb_alive || enc_multi)  verdict = VERDICT_FAIL;
    else if (dl_valid)           verdict = (agree && tod_fresh) ? VERDICT_PASS : VERDICT_FAIL;
    else                         verdict = VERDICT_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_ok  <= 1'b0;
      mode_out <= '0;
    end else begin
      case (verdict)
        VERDICT_PASS: begin
          mode_ok  <= 1'b1;
          mode_out <= dl_mode;
        end
        VERDICT_FAIL: mode_ok <= 1'b0;
        default:      ;
      endcase
    end
  end

  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !hb_alive |=> !mode_ok); // R3

  AST_MULTI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enc_multi |=> !mode_ok); // R5

  AST_MISMATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid && ev_live_q && (dl_mode != ev_mode_q) |=> !mode_ok); // R6

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_valid |=> $stable(mode_out)); // R7

  AST_RISE_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_ok) |-> $past(dl_valid)); // R8

endmodule

// File: tb/tb_mode_agree_guard.sv
`timescale 1ns/1ps
module tb_mode_agree_guard;

  localparam int NM = 8;
  localparam int MW = 3;
  localparam int TW = 24;
  localparam int L  = 40;   // 1000 kHz * 40 us / 1000

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NM-1:0] ev_strobe = '0;
  logic          dl_valid = 1'b0;
  logic [MW-1:0] dl_mode = '0;
  logic [TW-1:0] dl_tod = '0;
  logic          mode_ok;
  logic [MW-1:0] mode_out;

  always #5 clk = ~clk;

  mode_agree_guard #(.NUM_MODES(NM), .TOD_W(TW), .CLK_KHZ(1000), .TIMEOUT_US(40)) dut (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .dl_valid(dl_valid),
    .dl_mode(dl_mode), .dl_tod(dl_tod), .mode_ok(mode_ok), .mode_out(mode_out)
  );

  int tests = 0;
  int fails = 0;

  // Cycle model built from the requirements.
  int          m_cnt;
  bit          m_evv;
  int          m_evm;
  bit          m_hasref;
  logic [TW-1:0] m_ref;
  bit          m_ok;
  int          m_mode;
  logic [TW-1:0] tcnt = 24'h100;

  function automatic int ones(input logic [NM-1:0] s);
    int n = 0;
    for (int i = 0; i < NM; i++) if (s[i]) n++;
    return n;
  endfunction

  function automatic int first_idx(input logic [NM-1:0] s);
    for (int i = 0; i < NM; i++) if (s[i]) return i;
    return 0;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_evv = 0; m_evm = 0; m_hasref = 0; m_ref = '0; m_ok = 0; m_mode = 0;
  endtask

  task automatic model_edge(input logic [NM-1:0] s, input logic v,
                            input logic [MW-1:0] m, input logic [TW-1:0] t);
    int  n;
    bit  alive, pass;
    n = ones(s);
    alive = (m_cnt != 0);
    pass = alive && (n <= 1) && m_evv && m_hasref && (t != m_ref) && (int'(m) == m_evm);
    if (!alive || n > 1) m_ok = 0;
    else if (v) begin
      m_ok = pass;
      if (pass) m_mode = int'(m);
    end
    if (n == 1) begin m_evm = first_idx(s); m_evv = 1; m_cnt = L; end
    else begin
      if (n > 1) m_evv = 0;
      if (m_cnt != 0) m_cnt--;
    end
    if (v) begin m_ref = t; m_hasref = 1; end
  endtask

  task automatic check(input string tag);
    tests++;
    if (mode_ok !== m_ok) begin
      fails++;
      $display("FAIL %s mode_ok actual=%0d expected=%0d at %0t", tag, mode_ok, m_ok, $time);
    end
    tests++;
    if (mode_out !== MW'(m_mode)) begin
      fails++;
      $display("FAIL %s mode_out actual=%0d expected=%0d at %0t", tag, mode_out, m_mode, $time);
    end
  endtask

  task automatic cyc(input logic [NM-1:0] s, input logic v, input logic [MW-1:0] m,
                     input logic [TW-1:0] t, input string tag);
    @(negedge clk);
    ev_strobe = s; dl_valid = v; dl_mode = m; dl_tod = t;
    @(posedge clk);
    model_edge(s, v, m, t);
    #1;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc('0, 1'b0, '0, '0, tag);
  endtask

  function automatic logic [TW-1:0] nt();
    tcnt = tcnt + 1;
    return tcnt;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ev_strobe = '0; dl_valid = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 check("R1 in reset");
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1 check("R1 after release");
  endtask

  initial begin
    #(150000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [TW-1:0] same;
    int cur;
    int quiet;
    void'($urandom(32'd20240517));
    do_reset();

    // R9: frames before any strobe fail
    cyc('0, 1, 3'd0, nt(), "R9 no strobe");
    cyc('0, 1, 3'd0, nt(), "R9 no strobe");

    // R2: agreement passes
    cyc(8'h08, 0, '0, '0, "R2 strobe");
    cyc('0, 1, 3'd3, nt(), "R2 agree");
    // R4 stale stamp, R7 mode held
    same = tcnt;
    cyc('0, 1, 3'd3, same, "R4 stale R7 hold");
    cyc('0, 1, 3'd3, nt(), "R2 fresh again");
    // R6 mismatch
    cyc('0, 1, 3'd5, nt(), "R6 mismatch R7 hold");
    cyc('0, 1, 3'd3, nt(), "R2 recover");

    // R3 window edge: frame on L-th edge passes, next edge drops
    cyc(8'h04, 0, '0, '0, "R3 strobe");
    idle(L - 1, "R3 window");
    cyc('0, 1, 3'd2, nt(), "R3 last live edge");
    idle(1, "R3 expired");
    cyc('0, 1, 3'd2, nt(), "R3 frame after timeout");

    // R5 multi-strobe
    cyc(8'h02, 0, '0, '0, "R5 strobe");
    cyc('0, 1, 3'd1, nt(), "R5 pass before");
    cyc(8'h06, 0, '0, '0, "R5 multi");
    cyc('0, 1, 3'd1, nt(), "R5 discarded");
    cyc(8'h02, 0, '0, '0, "R5 single again");
    cyc('0, 1, 3'd1, nt(), "R5 recovered");

    // R8 strobe with frame in same cycle
    cyc(8'h10, 1, 3'd4, nt(), "R8 same cycle");
    cyc('0, 1, 3'd4, nt(), "R8 next frame");

    // R4 first frame after reset fails
    do_reset();
    cyc(8'h40, 0, '0, '0, "R4 strobe");
    cyc('0, 1, 3'd6, nt(), "R4 first frame");
    cyc('0, 1, 3'd6, nt(), "R4 second frame");

    // Random mix
    cur = 6; quiet = 0;
    for (int k = 0; k < 4000; k++) begin
      logic [NM-1:0] s;
      logic v;
      logic [MW-1:0] m;
      logic [TW-1:0] t;
      int r;
      s = '0;
      r = int'($urandom % 100);
      if (quiet > 0) quiet--;
      else if ($urandom % 150 == 0) quiet = L + 10 + int'($urandom % 20);
      else if (r < 10) begin
        if ($urandom % 6 == 0) cur = int'($urandom % NM);
        s[cur] = 1'b1;
      end else if (r == 10) begin
        s = NM'($urandom);
        if (ones(s) < 2) s = 8'h81;
      end
      v = ($urandom % 4 == 0);
      m = ($urandom % 8 == 0) ? MW'($urandom) : MW'(cur);
      t = ($urandom % 10 == 0) ? tcnt : nt();
      cyc(s, v, m, t, "RND R2 R3 R4 R5 R6 R7");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule